// File: doc/BRIEF.md
# Write-Through Cache with Per-Word Valid Bits

This block is a direct-mapped cache that sits between a processor's load/store port and main memory. Each line carries one address tag and an individual valid flag for every one-word subblock. A store never waits for a tag comparison. It writes its word and the tag into the line in the cycle it is accepted, and then corrects the line's valid flags. If the stored tag already matched, the addressed word is marked valid and the other words keep their flags. If the tag differed, only the addressed word is left valid. Every store is also forwarded to memory, so a line's old contents can be dropped at any time without losing data.

A load hits when the line's tag matches and the addressed word's flag is set. The data then returns in the cycle after acceptance. On a miss the cache fetches only the addressed word from memory. It installs that word with the same tag and flag correction a store uses, and passes the word on to the processor.

A five-state controller sequences the traffic. ST_IDLE accepts requests. ST_WR_SEND holds a write-through transfer until memory accepts it. ST_FILL_REQ holds a single-word read request. ST_FILL_WAIT waits for the read data. ST_RESP presents load data for one cycle. The transitions are:
- ST_IDLE→ST_WR_SEND on an accepted store.
- ST_IDLE→ST_RESP on a load hit.
- ST_IDLE→ST_FILL_REQ on a load miss.
- ST_WR_SEND→ST_IDLE when memory takes the write.
- ST_FILL_REQ→ST_FILL_WAIT when memory takes the read request.
- ST_FILL_WAIT→ST_RESP when the read data arrives.
- ST_RESP→ST_IDLE unconditionally.

Top module: `subblk_wt_cache`

## Requirements
- R1: After reset every valid flag is clear, so the first load to any address misses. During reset cpu_req_ready is 1 and mem_wr_valid, mem_rd_req_valid and cpu_rsp_valid are 0.
- R2: An accepted store writes its data and its tag into the line at the acceptance edge. mem_wr_valid is already 1 in the following cycle, and a later load of the same word hits and returns the stored data.
- R3: A store whose tag matches the line and whose word is already valid leaves that word valid and every other word's flag unchanged.
- R4: A store whose tag matches the line but whose word is invalid sets that word's flag and leaves every other word's flag unchanged.
- R5: A store whose tag differs from the line installs the new tag, leaves the written word valid and clears every other word's flag, so loads of the old tag and of other words in the line miss.
- R6: Each store produces exactly one memory write with the store's word address and data. mem_wr_valid, mem_wr_addr and mem_wr_data are held until mem_wr_ready.
- R7: A load hit returns the cached word with cpu_rsp_valid high for exactly one cycle, in the cycle after acceptance, and issues no memory read.
- R8: A load miss issues one read request for exactly the load's word address, held until mem_rd_req_ready. The returned word goes to the processor in the cycle after mem_rd_rsp_valid and is installed with the R4/R5 flag rules.
- R9: Addresses are word addresses. Bits [1:0] select the word within the line, the next clog2(SETS) bits (default bits [4:2]) select the line, and the remaining upper bits form the tag.
- R10: cpu_req_ready is 1 only in ST_IDLE, so no request is taken while a write-through or fill is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can take a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | DATA_W | Load data |
| mem_wr_valid | output | 1 | Write-through transfer present |
| mem_wr_ready | input | 1 | Memory takes the write |
| mem_wr_addr | output | ADDR_W | Write word address |
| mem_wr_data | output | DATA_W | Write data |
| mem_rd_req_valid | output | 1 | Single-word fill request present |
| mem_rd_req_ready | input | 1 | Memory takes the fill request |
| mem_rd_req_addr | output | ADDR_W | Fill word address |
| mem_rd_rsp_valid | input | 1 | Fill data present |
| mem_rd_rsp_data | input | DATA_W | Fill data |

## Verification
The hardest condition to reach from the ports is a line with a matching tag and a mix of valid and invalid words. This is the case that separates the R3 and R4 store paths from the R5 path. The stimulus builds it on purpose. A fill validates one word of a line, a store lands on a second, still-invalid word under the same tag, and loads then probe both written words and an untouched neighbour. Each probe expects a hit or a miss, and the outcome is observed by counting fill requests at the memory port. A store with a foreign tag then follows, and loads of the old tag's words must miss yet still return the values written through to memory.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SEND,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_RESP
    } wtc_state_e;

    typedef enum logic [1:0] {
        UPD_REVALID,
        UPD_FILLIN,
        UPD_REPLACE
    } upd_kind_e;

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store
    import wtc_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int WORDS = 4,
    parameter int TAG_W = 11,
    parameter int IDX_W = 3,
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    output logic [WORDS-1:0] lk_valid,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [OFF_W-1:0] upd_off
);

    logic [TAG_W-1:0] tag_q [SETS];
    logic [WORDS-1:0] vld_q [SETS];

    logic [WORDS-1:0] sel_1h;
    logic [WORDS-1:0] cur_row;
    logic             cur_match;
    upd_kind_e        upd_kind;

    always_comb begin
        sel_1h    = WORDS'(1) << upd_off;
        cur_row   = vld_q[upd_idx];
        cur_match = (tag_q[upd_idx] == upd_tag);
        if (!cur_match)
            upd_kind = UPD_REPLACE;
        else if (cur_row[upd_off])
            upd_kind = UPD_REVALID;
        else
            upd_kind = UPD_FILLIN;
    end

    assign lk_tag   = tag_q[lk_idx];
    assign lk_valid = vld_q[lk_idx];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[s] <= '0;
                vld_q[s] <= '0;
            end else if (upd_en && (upd_idx == IDX_W'(s))) begin
                // the tag is written without waiting for the compare
                tag_q[s] <= upd_tag;
                unique case (upd_kind)
                    UPD_REVALID: vld_q[s] <= vld_q[s] | sel_1h;
                    UPD_FILLIN:  vld_q[s] <= vld_q[s] | sel_1h;
                    UPD_REPLACE: vld_q[s] <= sel_1h;
                    default:     vld_q[s] <= '0;
                endcase
            end
        end
    end

    // R5
    replace_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && (upd_kind == UPD_REPLACE) |=> vld_q[$past(upd_idx)] == $past(sel_1h));

    // R3
    match_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && (upd_kind != UPD_REPLACE) |=> vld_q[$past(upd_idx)] == ($past(cur_row) | $past(sel_1h)));

    // R2
    tag_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> tag_q[$past(upd_idx)] == $past(upd_tag));

endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] word_q [SETS][WORDS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (we && (wr_idx == IDX_W'(s)) && (wr_off == OFF_W'(w)))
                    word_q[s][w] <= wr_data;
            end
        end
    end

    assign rd_data = word_q[rd_idx][rd_off];

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              mem_rd_req_valid,
    input  logic              mem_rd_req_ready,
    output logic [ADDR_W-1:0] mem_rd_req_addr,
    input  logic              mem_rd_rsp_valid,
    input  logic [DATA_W-1:0] mem_rd_rsp_data,
    output logic              upd_en,
    output logic [ADDR_W-1:0] upd_addr,
    output logic [DATA_W-1:0] upd_data
);

    wtc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_data_q;
    logic [DATA_W-1:0] rsp_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && cpu_req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cpu_req_write) state_d = ST_WR_SEND;
                    else if (lk_hit)   state_d = ST_RESP;
                    else               state_d = ST_FILL_REQ;
                end
            end
            ST_WR_SEND:   if (mem_wr_ready)     state_d = ST_IDLE;
            ST_FILL_REQ:  if (mem_rd_req_ready) state_d = ST_FILL_WAIT;
            ST_FILL_WAIT: if (mem_rd_rsp_valid) state_d = ST_RESP;
            ST_RESP:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_addr_q <= '0;
            pend_data_q <= '0;
            rsp_q       <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                pend_addr_q <= cpu_req_addr;
                pend_data_q <= cpu_req_wdata;
                if (!cpu_req_write && lk_hit)
                    rsp_q <= lk_data;
            end
            if ((state_q == ST_FILL_WAIT) && mem_rd_rsp_valid)
                rsp_q <= mem_rd_rsp_data;
        end
    end

    always_comb begin
        cpu_req_ready    = 1'b0;
        cpu_rsp_valid    = 1'b0;
        mem_wr_valid     = 1'b0;
        mem_rd_req_valid = 1'b0;
        upd_en           = 1'b0;
        upd_addr         = pend_addr_q;
        upd_data         = mem_rd_rsp_data;
        unique case (state_q)
            ST_IDLE: begin
                cpu_req_ready = 1'b1;
                upd_en        = cpu_req_valid && cpu_req_write;
                upd_addr      = cpu_req_addr;
                upd_data      = cpu_req_wdata;
            end
            ST_WR_SEND:   mem_wr_valid     = 1'b1;
            ST_FILL_REQ:  mem_rd_req_valid = 1'b1;
            ST_FILL_WAIT: upd_en           = mem_rd_rsp_valid;
            ST_RESP:      cpu_rsp_valid    = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rsp_rdata   = rsp_q;
    assign mem_wr_addr     = pend_addr_q;
    assign mem_wr_data     = pend_data_q;
    assign mem_rd_req_addr = pend_addr_q;

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req_valid && !mem_rd_req_ready |=> mem_rd_req_valid && $stable(mem_rd_req_addr));

    // R7
    hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_ready && !cpu_req_write && lk_hit
        |=> cpu_rsp_valid && (cpu_rsp_rdata == $past(lk_data)));

    // R8
    fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL_WAIT) && mem_rd_rsp_valid
        |=> cpu_rsp_valid && (cpu_rsp_rdata == $past(mem_rd_rsp_data)));

    // R7
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);

endmodule

// File: rtl/subblk_wt_cache.sv
module subblk_wt_cache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              mem_rd_req_valid,
    input  logic              mem_rd_req_ready,
    output logic [ADDR_W-1:0] mem_rd_req_addr,
    input  logic              mem_rd_rsp_valid,
    input  logic [DATA_W-1:0] mem_rd_rsp_data
);

    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [OFF_W-1:0] lk_off, up_off;
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag, line_tag;
    logic [WORDS-1:0] line_valid;
    logic [DATA_W-1:0] lk_data;
    logic              lk_hit;

    logic              upd_en;
    logic [ADDR_W-1:0] upd_addr;
    logic [DATA_W-1:0] upd_data;

    assign lk_off = cpu_req_addr[OFF_W-1:0];
    assign lk_idx = cpu_req_addr[OFF_W +: IDX_W];
    assign lk_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign up_off = upd_addr[OFF_W-1:0];
    assign up_idx = upd_addr[OFF_W +: IDX_W];
    assign up_tag = upd_addr[ADDR_W-1 -: TAG_W];

    assign lk_hit = (line_tag == lk_tag) && line_valid[lk_off];

    wtc_tag_store #(
        .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_tag(line_tag), .lk_valid(line_valid),
        .upd_en(upd_en), .upd_idx(up_idx), .upd_tag(up_tag), .upd_off(up_off)
    );

    wtc_data_store #(
        .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_data (
        .clk(clk),
        .rd_idx(lk_idx), .rd_off(lk_off), .rd_data(lk_data),
        .we(upd_en), .wr_idx(up_idx), .wr_off(up_off), .wr_data(upd_data)
    );

    wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .lk_hit(lk_hit), .lk_data(lk_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_rd_req_valid(mem_rd_req_valid), .mem_rd_req_ready(mem_rd_req_ready),
        .mem_rd_req_addr(mem_rd_req_addr),
        .mem_rd_rsp_valid(mem_rd_rsp_valid), .mem_rd_rsp_data(mem_rd_rsp_data),
        .upd_en(upd_en), .upd_addr(upd_addr), .upd_data(upd_data)
    );

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid || mem_rd_req_valid) |-> !cpu_req_ready);

endmodule

// File: tb/sim_subblk_wt_cache.sv
`timescale 1ns/1ps
module sim_subblk_wt_cache;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid, cpu_req_ready, cpu_req_write;
    logic [AW-1:0] cpu_req_addr;
    logic [DW-1:0] cpu_req_wdata;
    logic          cpu_rsp_valid;
    logic [DW-1:0] cpu_rsp_rdata;
    logic          mem_wr_valid, mem_wr_ready;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          mem_rd_req_valid, mem_rd_req_ready;
    logic [AW-1:0] mem_rd_req_addr;
    logic          mem_rd_rsp_valid;
    logic [DW-1:0] mem_rd_rsp_data;

    always #2.5 clk = ~clk;

    subblk_wt_cache u0 (.*);

    int tests = 0, fails = 0;
    int fill_cnt = 0, wr_delay = 0, rd_delay = 0;
    int wcnt = 0, rcnt = 0, lat_cnt = -1;
    logic [AW-1:0] last_fill_addr = '0;
    logic [DW-1:0] memv [int];
    logic [DW-1:0] exp_rd_q [$];
    logic [AW+DW-1:0] exp_wr_q [$];

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        if (memv.exists(int'(a))) return memv[int'(a)];
        return 32'h5EED_0000 ^ {16'h0, a};
    endfunction

    // R9: word address = {tag, index[2:0], word[1:0]}
    function automatic logic [AW-1:0] mk(input int tag, input int idx, input int off);
        return {tag[10:0], idx[2:0], off[1:0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory write port model
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_wr_ready = 1'b0;
            wcnt = 0;
        end else if (mem_wr_ready) begin
            mem_wr_ready = 1'b0;
        end else if (mem_wr_valid) begin
            if (wcnt >= wr_delay) begin
                mem_wr_ready = 1'b1;
                wcnt = 0;
                memv[int'(mem_wr_addr)] = mem_wr_data;
                if (exp_wr_q.size() == 0) begin
                    chk("R6", "unexpected write", {16'h0, mem_wr_addr}, 32'hFFFF_FFFF);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_wr_q.pop_front();
                    chk("R6", "write addr", {16'h0, mem_wr_addr}, {16'h0, e[AW+DW-1:DW]});
                    chk("R6", "write data", mem_wr_data, e[DW-1:0]);
                end
            end else begin
                wcnt++;
            end
        end
    end

    // memory read port model
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rd_req_ready = 1'b0;
            mem_rd_rsp_valid = 1'b0;
            mem_rd_rsp_data  = '0;
            rcnt = 0;
            lat_cnt = -1;
        end else begin
            mem_rd_rsp_valid = 1'b0;
            if (mem_rd_req_ready) begin
                mem_rd_req_ready = 1'b0;
            end else if (mem_rd_req_valid) begin
                if (rcnt >= rd_delay) begin
                    mem_rd_req_ready = 1'b1;
                    rcnt = 0;
                    last_fill_addr = mem_rd_req_addr;
                    fill_cnt++;
                    lat_cnt = 2;
                end else begin
                    rcnt++;
                end
            end
            if (lat_cnt == 0) begin
                mem_rd_rsp_valid = 1'b1;
                mem_rd_rsp_data  = mem_val(last_fill_addr);
                lat_cnt = -1;
            end else if (lat_cnt > 0) begin
                lat_cnt--;
            end
        end
    end

    // response monitor (scoreboard)
    always @(negedge clk) begin
        if (rst_n && cpu_rsp_valid) begin
            if (exp_rd_q.size() == 0)
                chk("R7", "unexpected response", cpu_rsp_rdata, 32'hFFFF_FFFF);
            else
                chk("R7/R8", "load data", cpu_rsp_rdata, exp_rd_q.pop_front());
        end
    end

    task automatic wait_idle();
        while (!cpu_req_ready) @(negedge clk);
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wait_idle();
        exp_wr_q.push_back({a, d});
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1;
        cpu_req_addr = a; cpu_req_wdata = d;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk("R2", "write-through issued next cycle", {31'h0, mem_wr_valid}, 32'h1);
        if (wr_delay > 0)
            chk("R10", "ready low while write pending", {31'h0, cpu_req_ready}, 32'h0);
        wait_idle();
    endtask

    task automatic do_load(input logic [AW-1:0] a, input bit exp_hit, input string req);
        int f0;
        wait_idle();
        exp_rd_q.push_back(mem_val(a));
        f0 = fill_cnt;
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (exp_hit)
            chk(req, "hit response next cycle", {31'h0, cpu_rsp_valid}, 32'h1);
        @(negedge clk);
        wait_idle();
        chk(req, exp_hit ? "fills on hit" : "fills on miss", fill_cnt - f0, exp_hit ? 0 : 1);
        if (!exp_hit)
            chk(req, "fill address", {16'h0, last_fill_addr}, {16'h0, a});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
        cpu_req_addr = '0; cpu_req_wdata = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", "ready in reset", {31'h0, cpu_req_ready}, 32'h1);
        chk("R1", "no write in reset", {31'h0, mem_wr_valid}, 32'h0);
        chk("R1", "no fill in reset", {31'h0, mem_rd_req_valid}, 32'h0);
        chk("R1", "no response in reset", {31'h0, cpu_rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        do_load(mk(1, 2, 0), 1'b0, "R1");
        do_load(mk(1, 2, 0), 1'b1, "R7");
        do_load(mk(1, 2, 1), 1'b0, "R8");
        // R3: tag match, word valid
        do_store(mk(1, 2, 0), 32'hAAAA_0001);
        do_load(mk(1, 2, 0), 1'b1, "R3");
        do_load(mk(1, 2, 1), 1'b1, "R3");
        // R4: tag match, word invalid
        rd_delay = 2;
        do_store(mk(1, 2, 3), 32'hBBBB_0003);
        do_load(mk(1, 2, 3), 1'b1, "R4");
        do_load(mk(1, 2, 2), 1'b0, "R4");
        do_load(mk(1, 2, 0), 1'b1, "R4");
        // R5: tag mismatch
        do_store(mk(5, 2, 1), 32'hCCCC_0501);
        do_load(mk(5, 2, 1), 1'b1, "R5");
        do_load(mk(5, 2, 0), 1'b0, "R5");
        do_load(mk(1, 2, 3), 1'b0, "R5");
        // R8: a fill with a foreign tag replaces the line
        do_load(mk(5, 2, 0), 1'b0, "R8");
        do_load(mk(5, 2, 0), 1'b1, "R8");
        // R2: store into a never-used line, with a slow memory write (R6, R10)
        wr_delay = 4;
        do_store(mk(7, 5, 2), 32'hDDDD_0752);
        do_load(mk(7, 5, 2), 1'b1, "R2");
        do_load(mk(7, 5, 0), 1'b0, "R2");
        wr_delay = 1;
        // R9: neighbouring index is a separate line
        do_store(mk(3, 6, 1), 32'hEEEE_0361);
        do_load(mk(3, 7, 1), 1'b0, "R9");
        do_load(mk(3, 6, 1), 1'b1, "R9");
        rd_delay = 0;

        repeat (6) @(negedge clk);
        chk("R6", "pending writes", exp_wr_q.size(), 0);
        chk("R7", "pending responses", exp_rd_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule